// File: doc/BRIEF.md
# Line-Valid Window and Field Gate

This block produces the line-valid qualifier for an image sensor's output stream. It watches free-running column and row counters, a vertical sync and an odd/even field flag, and raises `href_o` only while the counters lie inside a programmed rectangle and the current field has been selected. Selection works in two stages. A power-of-two slot divider lets one field in every 2, 4 and so on up to 64 through. A field mode then passes odd fields, even fields, both or none. A one-shot single-frame request overrides both stages for exactly one odd/even pair.

Alongside the qualifier the block carries the pixel stream. Each pixel enters with its column and row. It leaves on `pix_o` with a `pix_vld_o` marker, late by a programmable number of clocks relative to `href_o`. An option stretches the window by four lines at its top and fills those lines with the black reference code. The sensor cannot be stalled, so the output stream has a valid marker and no ready. A consumer must accept every cycle in which `pix_vld_o` is high. All configuration arrives as plain inputs held steady by the surrounding logic.

Top module: `href_window_gen`

## Requirements
- R1: After reset `href_o`, `pix_vld_o` and `pix_o` are all zero.
- R2: In full resolution (`qcif_i`=0) a horizontal register step is two columns. The line is valid for columns 2*`h_start_i` up to 2*`h_end_i`-1. `href_o` reflects the counters one clock after they are presented.
- R3: In quarter resolution (`qcif_i`=1) a horizontal step is one column. The line is valid for columns `h_start_i` up to `h_end_i`-1.
- R4: Rows `v_start_i` up to `v_end_i`-1 are inside the window. No other rows are inside it when the black-line option is off.
- R5: If `h_start_i` < 0x38, `h_end_i` > 0xEC, `h_start_i` >= `h_end_i`, `v_start_i` < 0x03, `v_end_i` > 0x94 or `v_start_i` >= `v_end_i`, `href_o` stays low.
- R6: `mode_i` selects the fields. 0 passes none, 1 passes fields with `field_odd_i`=1, 2 passes fields with `field_odd_i`=0, and 3 passes both. The decision is taken at each rising edge of `vsync_i` and holds until the next one.
- R7: A 6-bit field counter starts at zero after reset and advances at every rising edge of `vsync_i`. A nonzero `slot_i` whose highest set bit is k passes a field only when the counter is a multiple of 2^(k+1). Before the first rising edge of `vsync_i`, no field is passed.
- R8: With `slot_i`=0 every field passes the slot stage, and all pixel data inside the window is replaced by the black code 0x10.
- R9: A pulse on `single_req_i` arms a request. The next field that starts with `field_odd_i`=1, and the field after it, pass regardless of mode and slot. The request then clears itself.
- R10: With `black_en_i`=1 the window extends to row `v_end_i`+3. Rows `v_start_i` to `v_start_i`+3 carry the black code 0x10 instead of pixel data.
- R11: With `shift_i`=N, `pix_vld_o` and `pix_o` appear N+1 clocks after the pixel and counters are presented, N from 0 to 255. `pix_vld_o` follows the same window as `href_o`.
- R12: `pix_o` is zero whenever `pix_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_i | input | 10 | Column counter |
| row_i | input | 9 | Row counter |
| vsync_i | input | 1 | Vertical sync; rising edge starts a field |
| field_odd_i | input | 1 | 1 while the field is odd |
| qcif_i | input | 1 | 1 selects quarter resolution horizontal units |
| h_start_i | input | 8 | Horizontal window start |
| h_end_i | input | 8 | Horizontal window end |
| v_start_i | input | 8 | First window row |
| v_end_i | input | 8 | Row after the last window row |
| shift_i | input | 8 | Data delay in clocks |
| slot_i | input | 6 | Field slot divider |
| mode_i | input | 2 | Field mode |
| single_req_i | input | 1 | Single-frame transfer request pulse |
| black_en_i | input | 1 | Prepend four black lines |
| pix_i | input | 8 | Pixel data in step with the counters |
| href_o | output | 1 | Gated line-valid qualifier |
| pix_o | output | 8 | Delayed pixel data |
| pix_vld_o | output | 1 | Marks valid delayed data |

## Verification
`href_o` is due one clock after the counters and comes from a single register. `pix_vld_o` and `pix_o` are due N+1 clocks after their pixel, and a field decision counts from the clock that follows the rising edge of `vsync_i`. The bench drives on the falling edge and compares on the next falling edge, so every output is read half a clock after the rising edge that made it. It keeps a history of expected data indexed by drive cycle and compares the delayed outputs against the entry written N drives earlier. Data checks start only once a full delay's worth of history exists after each change of `shift_i`.

// File: rtl/href_pkg.sv
`timescale 1ns/1ps
package href_pkg;
  // Legal ranges of the window registers
  localparam logic [7:0] HS_MIN = 8'h38;
  localparam logic [7:0] HE_MAX = 8'hEC;
  localparam logic [7:0] VS_MIN = 8'h03;
  localparam logic [7:0] VE_MAX = 8'h94;
  // Lines of black reference added at the top of the window
  localparam int BLK_LINES = 4;

  typedef enum logic [1:0] {
    FM_NONE = 2'b00,
    FM_ODD  = 2'b01,
    FM_EVEN = 2'b10,
    FM_BOTH = 2'b11
  } fmode_e;
endpackage

// File: rtl/href_win_eval.sv
`timescale 1ns/1ps
module href_win_eval
  import href_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int ROW_W = 9
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             qcif_i,
  input  logic [7:0]       hs_i,
  input  logic [7:0]       he_i,
  input  logic [7:0]       vs_i,
  input  logic [7:0]       ve_i,
  input  logic             blk_en_i,
  output logic             in_win_o,
  output logic             blk_row_o
);
  logic             cfg_ok;
  logic [COL_W-1:0] h_lo, h_hi;
  logic [ROW_W-1:0] v_lo, v_hi, blk_hi;
  logic             in_h, in_v;

  // Reject anything outside the legal ranges or out of order
  always_comb begin
    cfg_ok = (hs_i >= HS_MIN) && (he_i <= HE_MAX) && (hs_i < he_i) &&
             (vs_i >= VS_MIN) && (ve_i <= VE_MAX) && (vs_i < ve_i);
  end

  // Horizontal units: two columns per step at full size, one at quarter size
  always_comb begin
    h_lo = qcif_i ? COL_W'(hs_i) : COL_W'({hs_i, 1'b0});
    h_hi = qcif_i ? COL_W'(he_i) : COL_W'({he_i, 1'b0});
  end

  always_comb begin
    v_lo   = ROW_W'(vs_i);
    blk_hi = v_lo + ROW_W'(BLK_LINES);
    v_hi   = ROW_W'(ve_i) + (blk_en_i ? ROW_W'(BLK_LINES) : ROW_W'(0));
  end

  always_comb begin
    in_h      = (col_i >= h_lo) && (col_i < h_hi);
    in_v      = (row_i >= v_lo) && (row_i < v_hi);
    in_win_o  = cfg_ok && in_h && in_v;
    blk_row_o = blk_en_i && (row_i >= v_lo) && (row_i < blk_hi);
  end
endmodule

// File: rtl/href_field_gate.sv
`timescale 1ns/1ps
module href_field_gate
  import href_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_i,
  input  logic              odd_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [1:0]        mode_i,
  input  logic              sreq_i,
  output logic              fen_o,
  output logic              slot_zero_o
);
  logic              vs_d;
  logic              fstart;
  logic [SLOT_W-1:0] fcnt;
  logic [SLOT_W-1:0] mask;
  logic              slot_hit, mode_ok;
  logic              pend, second, take;
  fmode_e            mode;

  assign mode        = fmode_e'(mode_i);
  assign fstart      = vsync_i & ~vs_d;
  assign slot_zero_o = (slot_i == '0);
  assign take        = pend & odd_i;

  // Period follows the highest set bit of the slot field
  always_comb begin
    mask = '0;
    for (int i = 0; i < SLOT_W; i++) begin
      if (slot_i[i]) mask = SLOT_W'((1 << (i + 1)) - 1);
    end
    slot_hit = slot_zero_o || ((fcnt & mask) == '0);
  end

  always_comb begin
    unique case (mode)
      FM_ODD:  mode_ok = odd_i;
      FM_EVEN: mode_ok = ~odd_i;
      FM_BOTH: mode_ok = 1'b1;
      default: mode_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_d   <= 1'b0;
      fcnt   <= '0;
      fen_o  <= 1'b0;
      pend   <= 1'b0;
      second <= 1'b0;
    end else begin
      vs_d <= vsync_i;
      pend <= sreq_i | (pend & ~(fstart & odd_i));
      if (fstart) begin
        fen_o  <= take | second | (slot_hit & mode_ok);
        second <= take;
        fcnt   <= fcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/href_shift_line.sv
`timescale 1ns/1ps
module href_shift_line #(
  parameter int DATA_W    = 8,
  parameter int MAX_SHIFT = 255,
  localparam int DEPTH    = MAX_SHIFT + 1,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  shift_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] dat_o
);
  logic [PTR_W-1:0]  wp, eff, rd;
  logic [PTR_W:0]    wsum;
  logic [DEPTH-1:0]  vmem;
  logic [DATA_W-1:0] dmem [DEPTH];

  // Clamp only when the pointer can name a slot beyond the ring
  generate
    if (DEPTH == (1 << PTR_W)) begin : g_full
      assign eff = shift_i;
    end else begin : g_clamp
      assign eff = (shift_i > PTR_W'(MAX_SHIFT)) ? PTR_W'(MAX_SHIFT) : shift_i;
    end
  endgenerate

  always_comb begin
    wsum = {1'b0, wp} + (PTR_W+1)'(DEPTH) - {1'b0, eff};
    rd   = (wp >= eff) ? (wp - eff) : PTR_W'(wsum);
  end

  always_ff @(posedge clk) begin
    dmem[wp] <= dat_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      vmem  <= '0;
      vld_o <= 1'b0;
      dat_o <= '0;
    end else begin
      wp       <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      vmem[wp] <= vld_i;
      if (eff == '0) begin
        vld_o <= vld_i;
        dat_o <= vld_i ? dat_i : '0;
      end else begin
        vld_o <= vmem[rd];
        dat_o <= vmem[rd] ? dmem[rd] : '0;
      end
    end
  end
endmodule

// File: rtl/href_window_gen.sv
`timescale 1ns/1ps
module href_window_gen #(
  parameter int DATA_W    = 8,
  parameter int COL_W     = 10,
  parameter int ROW_W     = 9,
  parameter int SLOT_W    = 6,
  parameter int MAX_SHIFT = 255,
  parameter logic [DATA_W-1:0] BLACK_LVL = DATA_W'(16),
  localparam int SHIFT_W  = (MAX_SHIFT + 1 > 1) ? $clog2(MAX_SHIFT + 1) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COL_W-1:0]   col_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic               vsync_i,
  input  logic               field_odd_i,
  input  logic               qcif_i,
  input  logic [7:0]         h_start_i,
  input  logic [7:0]         h_end_i,
  input  logic [7:0]         v_start_i,
  input  logic [7:0]         v_end_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [1:0]         mode_i,
  input  logic               single_req_i,
  input  logic               black_en_i,
  input  logic [DATA_W-1:0]  pix_i,
  output logic               href_o,
  output logic [DATA_W-1:0]  pix_o,
  output logic               pix_vld_o
);
  logic              in_win, blk_row, fen, slot_zero, href_raw;
  logic [DATA_W-1:0] dat_in;

  href_win_eval #(.COL_W(COL_W), .ROW_W(ROW_W)) u_win (
    .col_i    (col_i),
    .row_i    (row_i),
    .qcif_i   (qcif_i),
    .hs_i     (h_start_i),
    .he_i     (h_end_i),
    .vs_i     (v_start_i),
    .ve_i     (v_end_i),
    .blk_en_i (black_en_i),
    .in_win_o (in_win),
    .blk_row_o(blk_row)
  );

  href_field_gate #(.SLOT_W(SLOT_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync_i    (vsync_i),
    .odd_i      (field_odd_i),
    .slot_i     (slot_i),
    .mode_i     (mode_i),
    .sreq_i     (single_req_i),
    .fen_o      (fen),
    .slot_zero_o(slot_zero)
  );

  assign href_raw = in_win & fen;
  assign dat_in   = (blk_row | slot_zero) ? BLACK_LVL : pix_i;

  always_ff @(posedge clk) begin
    if (!rst_n) href_o <= 1'b0;
    else        href_o <= href_raw;
  end

  href_shift_line #(.DATA_W(DATA_W), .MAX_SHIFT(MAX_SHIFT)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift_i(shift_i),
    .vld_i  (href_raw),
    .dat_i  (dat_in),
    .vld_o  (pix_vld_o),
    .dat_o  (pix_o)
  );
endmodule

// File: rtl/href_window_gen_chk.sv
`timescale 1ns/1ps
module href_window_gen_chk
  import href_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int COL_W   = 10,
  parameter int ROW_W   = 9,
  parameter int SLOT_W  = 6,
  parameter int SHIFT_W = 8,
  parameter logic [DATA_W-1:0] BLACK_LVL = DATA_W'(16)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [COL_W-1:0]   col_i,
  input logic [ROW_W-1:0]   row_i,
  input logic [7:0]         h_start_i,
  input logic [7:0]         h_end_i,
  input logic [7:0]         v_start_i,
  input logic [7:0]         v_end_i,
  input logic [SHIFT_W-1:0] shift_i,
  input logic [SLOT_W-1:0]  slot_i,
  input logic               href_o,
  input logic [DATA_W-1:0]  pix_o,
  input logic               pix_vld_o
);
  logic cfg_bad;
  assign cfg_bad = (h_start_i < HS_MIN) || (h_end_i > HE_MAX) || (h_start_i >= h_end_i) ||
                   (v_start_i < VS_MIN) || (v_end_i > VE_MAX) || (v_start_i >= v_end_i);

  a_r2_left_of_window: assert property (@(posedge clk) disable iff (!rst_n)
    $past(col_i < COL_W'(h_start_i)) |-> !href_o);

  a_r4_above_window: assert property (@(posedge clk) disable iff (!rst_n)
    $past(row_i < ROW_W'(v_start_i)) |-> !href_o);

  a_r5_bad_config: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_bad) |-> !href_o);

  a_r8_black_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slot_i == '0 && shift_i == '0) && pix_vld_o) |-> (pix_o == BLACK_LVL));

  a_r11_zero_shift_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(shift_i) == '0) |-> (pix_vld_o == href_o));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld_o |-> (pix_o == '0));
endmodule

bind href_window_gen href_window_gen_chk #(
  .DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W), .SLOT_W(SLOT_W),
  .SHIFT_W(SHIFT_W), .BLACK_LVL(BLACK_LVL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .col_i    (col_i),
  .row_i    (row_i),
  .h_start_i(h_start_i),
  .h_end_i  (h_end_i),
  .v_start_i(v_start_i),
  .v_end_i  (v_end_i),
  .shift_i  (shift_i),
  .slot_i   (slot_i),
  .href_o   (href_o),
  .pix_o    (pix_o),
  .pix_vld_o(pix_vld_o)
);

// File: tb/sim_href_window_gen.sv
`timescale 1ns/1ps
module sim_href_window_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] col_i;
  logic [8:0] row_i;
  logic       vsync_i, field_odd_i, qcif_i, single_req_i, black_en_i;
  logic [7:0] h_start_i, h_end_i, v_start_i, v_end_i, shift_i, pix_i;
  logic [5:0] slot_i;
  logic [1:0] mode_i;
  logic       href_o, pix_vld_o;
  logic [7:0] pix_o;

  always #4 clk = ~clk;

  href_window_gen u0 (
    .clk(clk), .rst_n(rst_n), .col_i(col_i), .row_i(row_i), .vsync_i(vsync_i),
    .field_odd_i(field_odd_i), .qcif_i(qcif_i), .h_start_i(h_start_i),
    .h_end_i(h_end_i), .v_start_i(v_start_i), .v_end_i(v_end_i),
    .shift_i(shift_i), .slot_i(slot_i), .mode_i(mode_i),
    .single_req_i(single_req_i), .black_en_i(black_en_i), .pix_i(pix_i),
    .href_o(href_o), .pix_o(pix_o), .pix_vld_o(pix_vld_o)
  );

  int   n_vec = 0, n_bad = 0;
  int   cyc = 0, t0 = 0;
  bit   bfen = 0, bpend = 0, bsec = 0;
  int   bcnt = 0;
  logic       hv [0:1023];
  logic [7:0] hp [0:1023];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Window from the requirements (R2, R3, R4, R5, R10)
  function automatic bit ref_win(input int c, input int r);
    int hm;
    int vend;
    bit ok;
    hm   = qcif_i ? 1 : 2;
    ok   = (h_start_i >= 8'h38) && (h_end_i <= 8'hEC) && (h_start_i < h_end_i) &&
           (v_start_i >= 8'h03) && (v_end_i <= 8'h94) && (v_start_i < v_end_i);
    vend = int'(v_end_i) + (black_en_i ? 4 : 0);
    return ok && (c >= int'(h_start_i) * hm) && (c < int'(h_end_i) * hm) &&
           (r >= int'(v_start_i)) && (r < vend);
  endfunction

  task automatic tick(input int c, input int r, input logic [7:0] p,
                      input string req, input bit ch, input bit cd);
    bit         e;
    logic [7:0] d;
    int         idx;
    col_i = 10'(c);
    row_i = 9'(r);
    pix_i = p;
    e = ref_win(c, r) && bfen;
    d = ((black_en_i && r >= int'(v_start_i) && r < int'(v_start_i) + 4) || slot_i == 6'd0)
        ? 8'h10 : p;
    hv[cyc % 1024] = e;
    hp[cyc % 1024] = e ? d : 8'h00;
    @(negedge clk);
    if (ch) chk(href_o === e, req, int'(href_o), int'(e));
    if (cd && (cyc - int'(shift_i) >= t0)) begin
      idx = (cyc - int'(shift_i)) % 1024;
      chk(pix_vld_o === hv[idx], req, int'(pix_vld_o), int'(hv[idx]));
      chk(pix_o === hp[idx], req, int'(pix_o), int'(hp[idx]));
    end
    cyc++;
  endtask

  task automatic probe(input int c, input int r, input string req);
    tick(c, r, 8'h5A, req, 1'b1, 1'b0);
  endtask

  // Field start plus the bench's own model of R6, R7 and R9
  task automatic field(input bit odd);
    bit ovr, hit, mok;
    int per;
    vsync_i     = 1'b1;
    field_odd_i = odd;
    tick(0, 0, 8'h00, "R6", 1'b1, 1'b0);
    vsync_i = 1'b0;
    ovr  = (bpend && odd) || bsec;
    bsec = bpend && odd;
    if (bpend && odd) bpend = 0;
    per = 1;
    for (int i = 0; i < 6; i++) if (slot_i[i]) per = 2 << i;
    hit = (slot_i == 6'd0) || (bcnt % per == 0);
    case (mode_i)
      2'd1:    mok = odd;
      2'd2:    mok = !odd;
      2'd3:    mok = 1'b1;
      default: mok = 1'b0;
    endcase
    bfen = ovr || (hit && mok);
    bcnt = (bcnt + 1) % 64;
    tick(0, 0, 8'h00, "R6", 1'b1, 1'b0);
  endtask

  task automatic open_field();
    for (int k = 0; k < 3 && !bfen; k++) field(k % 2 == 0);
  endtask

  task automatic set_win(input logic [7:0] hs, input logic [7:0] he,
                         input logic [7:0] vs, input logic [7:0] ve);
    h_start_i = hs; h_end_i = he; v_start_i = vs; v_end_i = ve;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] bad [7][4];
    int         slots [8];
    int         shifts [4];
    bad = '{'{8'hEC,8'hEC,8'h03,8'h06}, '{8'h38,8'hED,8'h03,8'h06},
            '{8'h37,8'h40,8'h03,8'h06}, '{8'h38,8'h40,8'h02,8'h06},
            '{8'h38,8'h40,8'h03,8'h95}, '{8'h40,8'h38,8'h03,8'h06},
            '{8'h38,8'h40,8'h06,8'h06}};
    slots  = '{1, 2, 4, 8, 16, 32, 6, 40};
    shifts = '{0, 1, 7, 255};

    rst_n = 1'b0; col_i = '0; row_i = '0; vsync_i = 0; field_odd_i = 0;
    qcif_i = 0; single_req_i = 0; black_en_i = 0; pix_i = '0;
    shift_i = 8'd0; slot_i = 6'd1; mode_i = 2'd3;
    set_win(8'h38, 8'h40, 8'h03, 8'h06);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(href_o === 1'b0, "R1", int'(href_o), 0);
    chk(pix_vld_o === 1'b0, "R1", int'(pix_vld_o), 0);
    chk(pix_o === 8'h00, "R1", int'(pix_o), 0);
    // R7: no field passed before the first field start
    probe(115, 4, "R7");

    field(1'b1);
    for (int c = 100; c <= 140; c++) probe(c, 4, "R2");
    for (int r = 0; r <= 10; r++) probe(115, r, "R4");
    qcif_i = 1;
    for (int c = 50; c <= 70; c++) probe(c, 4, "R3");
    qcif_i = 0;
    set_win(8'hEB, 8'hEC, 8'h03, 8'h06);
    for (int c = 465; c <= 475; c++) probe(c, 4, "R2");
    set_win(8'h38, 8'h40, 8'h93, 8'h94);
    for (int r = 8'h91; r <= 8'h96; r++) probe(115, r, "R4");

    for (int b = 0; b < 7; b++) begin
      set_win(bad[b][0], bad[b][1], bad[b][2], bad[b][3]);
      for (int c = 108; c <= 132; c += 2) probe(c, 4, "R5");
      probe(120, int'(bad[b][2]), "R5");
    end
    set_win(8'h38, 8'h40, 8'h03, 8'h06);

    // R6: every field mode over odd and even fields
    slot_i = 6'd0;
    for (int m = 0; m < 4; m++) begin
      mode_i = 2'(m);
      for (int f = 0; f < 4; f++) begin
        field(f % 2 == 0);
        probe(115, 4, "R6");
      end
    end

    // R7: slot divider periods, including values with several bits set
    mode_i = 2'd3;
    foreach (slots[s]) begin
      int per;
      slot_i = 6'(slots[s]);
      per = 1;
      for (int i = 0; i < 6; i++) if (slot_i[i]) per = 2 << i;
      for (int f = 0; f < 2 * per; f++) begin
        field(f % 2 == 0);
        probe(115, 4, "R7");
      end
    end

    // R9: single-frame override in the none mode
    mode_i = 2'd0;
    slot_i = 6'd1;
    field(1'b1);
    probe(115, 4, "R9");
    single_req_i = 1'b1;
    tick(0, 0, 8'h00, "R9", 1'b1, 1'b0);
    single_req_i = 1'b0;
    bpend = 1;
    for (int f = 0; f < 5; f++) begin
      field(f % 2 == 1);
      probe(115, 4, "R9");
    end

    // R10: four black lines ahead of the window
    mode_i = 2'd3;
    open_field();
    black_en_i = 1;
    t0 = cyc;
    for (int r = 0; r <= 12; r++) tick(115, r, 8'(r + 8'h40), "R10", 1'b1, 1'b1);
    black_en_i = 0;

    // R8: slot zero forces black data
    slot_i = 6'd0;
    field(1'b1);
    t0 = cyc;
    for (int c = 105; c <= 135; c++) tick(c, 4, 8'(c), "R8", 1'b1, 1'b1);

    // R11 and R12: data delay sweep
    slot_i = 6'd1;
    open_field();
    foreach (shifts[s]) begin
      shift_i = 8'(shifts[s]);
      t0 = cyc;
      for (int k = 0; k <= shifts[s] + 300; k++)
        tick(100 + k % 40, 4, 8'(k * 7 + 3), "R11/R12", 1'b1, 1'b1);
    end

    summary();
    $finish;
  end
endmodule